// File: doc/BRIEF.md
# Calendar Time Counter Core

This block keeps wall-clock time and the calendar date in hardware. A clock enable at 32768 Hz feeds a prescaler; each time the prescaler wraps, the block advances seconds, and the carries ripple into minutes, hours, day of week, day of month, month, two-digit year and century. Software stops the counters with a freeze bit, loads a new time through a small write port, then releases the freeze. Two mode bits choose how the eight output bytes are encoded: BCD or plain binary, and a 24-hour or 12-hour hours byte.

The prescaler is driven by a small state machine. It has four states. ST_RUN counts ticks outside the update window. ST_WINDOW covers the last ticks before an update and drives the update-in-progress flag. ST_HOLD freezes the prescaler for the divider codes that are neither running nor reset. ST_DIVRST holds the prescaler at its midpoint.

The transitions are as follows. Any state goes to ST_DIVRST while the divider code is 6 or 7. Any state goes to ST_HOLD while the code is 3, 4 or 5. With a running code (0 to 2), ST_RUN goes to ST_WINDOW when the next prescaler value reaches the window start and freeze is clear. ST_WINDOW returns to ST_RUN at the wrap, which is the update, or at once when freeze is raised. ST_DIVRST and ST_HOLD return to ST_RUN or ST_WINDOW when a running code comes back. The calendar registers advance on the wrap tick. A registered strobe is high for exactly the one cycle in which the new values first appear.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 1/1, year 0 and century 20. In BCD 24-hour mode this gives hour byte 0x00 and century byte 0x20.
- R2: Time advances only while freeze (`set_freeze`) is 0 and `div_sel` is 2 or less. Raising freeze during the update window drops `uip` on the next cycle. While frozen there is no strobe and no `uip`.
- R3: With `div_sel[2:1]`=11 there is no update and `uip` stays low. On release to a running code, the first update comes exactly 2^(DIV_BITS-1) ticks later.
- R4: `uip` is high for exactly the final UIP_TICKS ticks before each update. `upd_strobe` is high for one cycle, the cycle in which the counters first show the advanced values.
- R5: Seconds and minutes roll over from 59 to 0, and hours from 23 to 0, each carrying into the next field.
- R6: Day of month rolls after 28, 29, 30 or 31 days according to month and leap year, with a leap year being year mod 4 = 0 (year 00 included). It then carries into month, and month 12 into year. Day of week counts 1 to 7 and wraps to 1 at midnight.
- R7: Year 99 rolls to 00 and increments the century, which counts modulo 100.
- R8: With `bin_mode`=1 each byte is the plain binary value. With `bin_mode`=0 each byte is two BCD digits, tens in bits 7:4.
- R9: With `hr24`=0 the hour byte shows 1 to 12 with bit 7 set for PM. Hour 0 shows as 12 AM and hour 12 as 12 PM. With `hr24`=1 it shows 0 to 23 and bit 7 is clear.
- R10: A write (`wr_en`) takes effect only while frozen (freeze set or `div_sel` above 2), and is otherwise ignored. `wr_data` is decoded with the current `bin_mode` and `hr24` settings. `wr_sel` codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century.
- R11: `div_sel` of 3, 4 or 5 freezes the prescaler. No update and no `uip` occur, and writes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | 32768 Hz clock enable |
| div_sel | input | 3 | Divider select code |
| set_freeze | input | 1 | Freeze bit; stops updates |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour hours byte |
| wr_en | input | 1 | Write strobe for one counter field |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Encoded write value |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| month_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte (mod 100) |
| cent_o | output | 8 | Century byte |
| uip | output | 1 | Update in progress |
| upd_strobe | output | 1 | One-cycle update-ended strobe |

## Verification
The hardest situations to reach are the deep carries: the New Year century rollover and the February ends in leap and non-leap years. Each would take many simulated seconds if the bench only let time run. The stimulus instead freezes the block and writes a time one or two seconds before the boundary, then releases it. The bench is built with a short prescaler so that each second costs only tens of ticks. Freezes are timed right after a strobe, and a divider reset realigns the phase, so that every update window is seen in full.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WINDOW,
        ST_HOLD,
        ST_DIVRST
    } tick_state_e;

    typedef struct packed {
        logic [6:0] cen;
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{cen: 7'd20, yr: 7'd0, mon: 4'd1, dom: 5'd1,
                                   dow: 3'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        logic [4:0] d;
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
            4'd2:                    d = leap ? 5'd29 : 5'd28;
            default:                 d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_cal_pkg::*;
#(
    parameter int DIV_BITS  = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div_sel,
    input  logic       set_freeze,
    output logic       adv,
    output logic       uip,
    output logic       frozen
);
    localparam logic [DIV_BITS-1:0] CNT_MAX   = '1;
    localparam logic [DIV_BITS-1:0] HALF      = {1'b1, {(DIV_BITS-1){1'b0}}};
    localparam logic [DIV_BITS-1:0] WIN_START = CNT_MAX - DIV_BITS'(UIP_TICKS - 1);

    tick_state_e         state, state_nx;
    logic [DIV_BITS-1:0] cnt, cnt_nx;
    logic                div_rst, run_sel;

    assign div_rst = (div_sel[2:1] == 2'b11);
    assign run_sel = (div_sel <= 3'd2);

    // next-state and prescaler logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        adv      = 1'b0;
        if (div_rst) begin
            state_nx = ST_DIVRST;
            cnt_nx   = HALF;
        end else if (!run_sel) begin
            state_nx = ST_HOLD;
        end else begin
            if (tick) cnt_nx = cnt + 1'b1;
            unique case (state)
                ST_WINDOW:                  adv = tick && !set_freeze && (cnt == CNT_MAX);
                ST_RUN, ST_HOLD, ST_DIVRST: adv = 1'b0;
            endcase
            state_nx = (!set_freeze && cnt_nx >= WIN_START) ? ST_WINDOW : ST_RUN;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        uip    = (state == ST_WINDOW);
        frozen = set_freeze || !run_sel;
    end

    p_uip_needs_clear_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> $past(!set_freeze));
    p_divrst_no_uip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !uip);
    p_release_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DIVRST && state != ST_DIVRST && state != ST_HOLD)
        |-> (cnt == HALF || cnt == HALF + 1'b1));
    p_hold_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !div_rst && !run_sel) |=> $stable(cnt));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       frozen,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       bin_mode,
    input  logic       hr24,
    output cal_t       cal,
    output logic       strobe
);
    cal_t       nxt;
    logic [6:0] wval, hraw;
    logic [4:0] h_int;
    logic       wr_ok;

    // carry chain for one second
    always_comb begin
        nxt = cal;
        if (cal.sec != 6'd59) begin
            nxt.sec = cal.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cal.min != 6'd59) begin
                nxt.min = cal.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cal.hour != 5'd23) begin
                    nxt.hour = cal.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.dow  = (cal.dow >= 3'd7) ? 3'd1 : cal.dow + 3'd1;
                    if (cal.dom < month_len(cal.mon, cal.yr[1:0] == 2'b00)) begin
                        nxt.dom = cal.dom + 5'd1;
                    end else begin
                        nxt.dom = 5'd1;
                        if (cal.mon < 4'd12) begin
                            nxt.mon = cal.mon + 4'd1;
                        end else begin
                            nxt.mon = 4'd1;
                            if (cal.yr < 7'd99) begin
                                nxt.yr = cal.yr + 7'd1;
                            end else begin
                                nxt.yr  = 7'd0;
                                nxt.cen = (cal.cen >= 7'd99) ? 7'd0 : cal.cen + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // write decode in the current encoding
    always_comb begin
        wr_ok = wr_en && frozen;
        wval  = bin_mode ? wr_data[6:0] : from_bcd(wr_data);
        hraw  = bin_mode ? wr_data[6:0] : from_bcd({1'b0, wr_data[6:0]});
        if (hr24) h_int = hraw[4:0];
        else      h_int = ((hraw == 7'd12) ? 5'd0 : hraw[4:0]) + (wr_data[7] ? 5'd12 : 5'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal    <= CAL_RESET;
            strobe <= 1'b0;
        end else begin
            strobe <= adv;
            if (adv) begin
                cal <= nxt;
            end else if (wr_ok) begin
                case (wr_sel)
                    3'd0: cal.sec  <= wval[5:0];
                    3'd1: cal.min  <= wval[5:0];
                    3'd2: cal.hour <= h_int;
                    3'd3: cal.dow  <= wval[2:0];
                    3'd4: cal.dom  <= wval[4:0];
                    3'd5: cal.mon  <= wval[3:0];
                    3'd6: cal.yr   <= wval;
                    default: cal.cen <= wval;
                endcase
            end
        end
    end

    p_stable_when_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !wr_en) |=> $stable(cal));
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    p_adv_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !frozen);

endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
    import rtc_cal_pkg::*;
(
    input  cal_t       cal,
    input  logic       bin_mode,
    input  logic       hr24,
    output logic [7:0] sec_b,
    output logic [7:0] min_b,
    output logic [7:0] hour_b,
    output logic [7:0] wday_b,
    output logic [7:0] mday_b,
    output logic [7:0] month_b,
    output logic [7:0] year_b,
    output logic [7:0] cent_b
);
    function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    logic [4:0] h12;

    always_comb begin
        sec_b   = enc(7'(cal.sec), bin_mode);
        min_b   = enc(7'(cal.min), bin_mode);
        wday_b  = enc(7'(cal.dow), bin_mode);
        mday_b  = enc(7'(cal.dom), bin_mode);
        month_b = enc(7'(cal.mon), bin_mode);
        year_b  = enc(cal.yr, bin_mode);
        cent_b  = enc(cal.cen, bin_mode);
        if (cal.hour == 5'd0)      h12 = 5'd12;
        else if (cal.hour > 5'd12) h12 = cal.hour - 5'd12;
        else                       h12 = cal.hour;
        if (hr24) hour_b = enc(7'(cal.hour), bin_mode);
        else      hour_b = enc(7'(h12), bin_mode) | ((cal.hour >= 5'd12) ? 8'h80 : 8'h00);
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV_BITS  = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic [2:0] div_sel,
    input  logic       set_freeze,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic       uip,
    output logic       upd_strobe
);
    logic adv, frozen;
    cal_t cal;

    rtc_tick_fsm #(.DIV_BITS(DIV_BITS), .UIP_TICKS(UIP_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .div_sel(div_sel),
        .set_freeze(set_freeze), .adv(adv), .uip(uip), .frozen(frozen)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv), .frozen(frozen), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .bin_mode(bin_mode), .hr24(hr24),
        .cal(cal), .strobe(upd_strobe)
    );

    rtc_encode u_enc (
        .cal(cal), .bin_mode(bin_mode), .hr24(hr24),
        .sec_b(sec_o), .min_b(min_o), .hour_b(hour_o), .wday_b(wday_o),
        .mday_b(mday_o), .month_b(month_o), .year_b(year_o), .cent_b(cent_o)
    );

    p_strobe_after_uip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> $past(uip));
    p_no_strobe_divrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel[2:1] == 2'b11) |=> !upd_strobe);

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    localparam int DB = 6;
    localparam int HALF_T = 1 << (DB - 1);

    logic clk = 1'b0;
    logic rst_n, tick, set_freeze, bin_mode, hr24, wr_en;
    logic [2:0] div_sel, wr_sel;
    logic [7:0] wr_data;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, cent_o;
    logic uip, upd_strobe;

    int errs = 0, checks = 0;
    int win = 0, last_win = 0;
    int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_cen;

    always #10 clk = ~clk;

    rtc_calendar_core #(.DIV_BITS(DB), .UIP_TICKS(8)) dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .div_sel(div_sel),
        .set_freeze(set_freeze), .bin_mode(bin_mode), .hr24(hr24),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o),
        .uip(uip), .upd_strobe(upd_strobe)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int b_enc(input int v, input bit bin);
        return bin ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int b_hour(input int h, input bit bin, input bit h24);
        int h12;
        if (h24) return b_enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return b_enc(h12, bin) | ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int b_dim(input int mon, input int yr);
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    task automatic model_adv();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_dom++;
                    if (m_dom > b_dim(m_mon, m_yr)) begin
                        m_dom = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr++;
                            if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_all(input string req);
        check(sec_o == 8'(b_enc(m_sec, bin_mode)), req, "sec", sec_o, b_enc(m_sec, bin_mode));
        check(min_o == 8'(b_enc(m_min, bin_mode)), req, "min", min_o, b_enc(m_min, bin_mode));
        check(hour_o == 8'(b_hour(m_hr, bin_mode, hr24)), req, "hour", hour_o, b_hour(m_hr, bin_mode, hr24));
        check(wday_o == 8'(b_enc(m_dow, bin_mode)), req, "wday", wday_o, b_enc(m_dow, bin_mode));
        check(mday_o == 8'(b_enc(m_dom, bin_mode)), req, "mday", mday_o, b_enc(m_dom, bin_mode));
        check(month_o == 8'(b_enc(m_mon, bin_mode)), req, "month", month_o, b_enc(m_mon, bin_mode));
        check(year_o == 8'(b_enc(m_yr, bin_mode)), req, "year", year_o, b_enc(m_yr, bin_mode));
        check(cent_o == 8'(b_enc(m_cen, bin_mode)), req, "cent", cent_o, b_enc(m_cen, bin_mode));
    endtask

    // one clock: inputs driven and outputs sampled at the falling edge
    task automatic cyc(input bit t);
        bit u;
        u = uip;
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        if (u && t) win++;
        else if (!u) win = 0;
        if (upd_strobe) begin last_win = win; win = 0; end
    endtask

    task automatic put(input int sel, input int val);
        wr_sel = 3'(sel); wr_data = 8'(val); wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_model();
        put(0, b_enc(m_sec, bin_mode));
        put(1, b_enc(m_min, bin_mode));
        put(2, b_hour(m_hr, bin_mode, hr24));
        put(3, b_enc(m_dow, bin_mode));
        put(4, b_enc(m_dom, bin_mode));
        put(5, b_enc(m_mon, bin_mode));
        put(6, b_enc(m_yr, bin_mode));
        put(7, b_enc(m_cen, bin_mode));
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int d, input int mo, input int y, input int c);
        m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_dom = d; m_mon = mo; m_yr = y; m_cen = c;
        set_freeze = 1'b1; cyc(0);
        load_model();
        check_all("R10");
        set_freeze = 1'b0; cyc(0);
    endtask

    task automatic run_second(input string req, input bit rnd);
        int n = 0;
        bit seen = 0;
        while (!seen && n < 3000) begin
            cyc(rnd ? bit'($urandom % 2) : 1'b1);
            n++;
            seen = upd_strobe;
        end
        if (!seen) begin
            check(1'b0, req, "no update", 0, 1);
        end else begin
            model_adv();
            check_all(req);
            check(last_win == 8, "R4", "uip ticks", last_win, 8);
            cyc(1'b0);
            check(upd_strobe == 1'b0, "R4", "strobe width", upd_strobe, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int strobes, uips, n;
        void'($urandom(32'd4242));
        rst_n = 1'b0; tick = 1'b0; set_freeze = 1'b0; bin_mode = 1'b0; hr24 = 1'b1;
        wr_en = 1'b0; div_sel = 3'd2; wr_sel = 3'd0; wr_data = 8'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc(0);
        // R1 reset state
        m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0; m_cen = 20;
        check_all("R1");
        check(uip == 1'b0 && upd_strobe == 1'b0, "R1", "flags", {uip, upd_strobe}, 0);

        // R5 R6 R7 New Year with century carry
        set_time(58, 59, 23, 7, 31, 12, 99, 20);
        run_second("R5", 1'b0);
        run_second("R7", 1'b0);
        // R6 February, non-leap and leap; 30-day month
        set_time(59, 59, 23, 3, 28, 2, 1, 20);
        run_second("R6", 1'b1);
        set_time(59, 59, 23, 3, 28, 2, 4, 20);
        run_second("R6", 1'b1);
        set_time(59, 59, 23, 4, 29, 2, 4, 20);
        run_second("R6", 1'b1);
        set_time(59, 59, 23, 5, 30, 4, 10, 20);
        run_second("R6", 1'b1);
        set_time(59, 59, 23, 6, 28, 2, 0, 21);
        run_second("R6", 1'b1);

        // R8 binary encoding, live mode change
        bin_mode = 1'b1; cyc(0);
        check_all("R8");
        // R9 12-hour format: 12 AM, 12 PM, 11 PM
        hr24 = 1'b0;
        set_time(59, 59, 23, 1, 3, 3, 20, 20);
        run_second("R9", 1'b0);
        check(hour_o == 8'h0C, "R9", "12AM bin", hour_o, 8'h0C);
        bin_mode = 1'b0;
        set_time(59, 59, 11, 1, 3, 3, 20, 20);
        run_second("R9", 1'b0);
        check(hour_o == 8'h92, "R9", "12PM bcd", hour_o, 8'h92);
        set_time(59, 59, 22, 1, 3, 3, 20, 20);
        run_second("R9", 1'b0);
        check(hour_o == 8'h91, "R9", "11PM bcd", hour_o, 8'h91);
        hr24 = 1'b1; cyc(0);
        check(hour_o == 8'h23, "R9", "24h", hour_o, 8'h23);

        // R10 write while running is ignored
        put(0, 8'h45);
        put(7, 8'h19);
        check_all("R10");

        // R2 raising freeze inside the window drops uip
        n = 0;
        while (!uip && n < 500) begin cyc(1'b1); n++; end
        check(uip == 1'b1, "R2", "window reached", uip, 1);
        set_freeze = 1'b1; cyc(1'b0);
        check(uip == 1'b0, "R2", "uip cleared by freeze", uip, 0);
        strobes = 0; uips = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1);
            if (upd_strobe) strobes++;
            if (uip) uips++;
        end
        check(strobes == 0 && uips == 0, "R2", "frozen activity", strobes + uips, 0);
        check_all("R2");

        // R3 divider reset, then release with freeze clear
        div_sel = 3'd6; cyc(1'b0);
        set_freeze = 1'b0;
        strobes = 0; uips = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1);
            if (upd_strobe) strobes++;
            if (uip) uips++;
        end
        check(strobes == 0 && uips == 0, "R3", "divider reset activity", strobes + uips, 0);
        check_all("R3");
        div_sel = 3'd2;
        n = 0;
        while (!upd_strobe && n < 500) begin cyc(1'b1); n++; end
        check(n == HALF_T, "R3", "ticks to first update", n, HALF_T);
        model_adv();
        check_all("R3");
        check(last_win == 8, "R4", "uip ticks after release", last_win, 8);
        cyc(1'b0);

        // R11 hold codes freeze, writes accepted
        div_sel = 3'd4; cyc(1'b0);
        strobes = 0; uips = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1);
            if (upd_strobe) strobes++;
            if (uip) uips++;
        end
        check(strobes == 0 && uips == 0, "R11", "hold activity", strobes + uips, 0);
        m_min = 33;
        put(1, b_enc(33, bin_mode));
        check_all("R11");
        div_sel = 3'd2; cyc(1'b0);
        run_second("R11", 1'b0);

        // random times and modes, mixed with rollover-biased values
        for (int it = 0; it < 30; it++) begin
            int nsec;
            set_freeze = 1'b1; cyc(1'b0);
            bin_mode = 1'($urandom % 2);
            hr24 = 1'($urandom % 2);
            m_sec = ($urandom % 3 == 0) ? 59 : $urandom % 60;
            m_min = ($urandom % 2 == 0) ? 59 : $urandom % 60;
            m_hr = ($urandom % 2 == 0) ? 23 : $urandom % 24;
            m_dow = 1 + $urandom % 7;
            m_mon = 1 + $urandom % 12;
            m_yr = $urandom % 100;
            m_cen = $urandom % 100;
            m_dom = ($urandom % 2 == 0) ? b_dim(m_mon, m_yr) : 1 + $urandom % 28;
            set_time(m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_cen);
            nsec = 1 + $urandom % 3;
            for (int k = 0; k < nsec; k++) run_second(bin_mode ? "R8" : "R6", 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule